// File: doc/BRIEF.md
# Three-wire half-duplex SPI master

This block is a serial master for peripherals that share a single data wire in both directions. It drives a serial clock and an active-low select. The shared data wire is handled through three plain signals: the outgoing bit, an output enable for the pad's tri-state buffer, and the incoming bit from the pad. Each transfer moves one byte, most significant bit first. The clock idles low. Data is valid on each rising clock edge, and the master moves its output only on falling edges.

The host chooses the direction one byte at a time. Pushing a byte queues a write. Pulsing the read request queues a read. Both kinds of request go into one command queue and are served strictly in the order they arrived. During a write the master drives the wire for the whole time the select is low. During a read the master never drives the wire. The slave changes the wire on falling edges, and the master samples it on rising edges. Each received byte is placed in a receive queue, whose oldest entry is always shown on the read-data port.

The clock rate comes from a divider value. Each half period of the serial clock lasts `div + 1` system clocks. The select goes low one half period before the first rising edge and rises one half period after the last falling edge.

Top module: `spi3w_master`

## Requirements
- R1: After reset the select output is high, the serial clock is low, the data output enable is low, both queues report empty, and neither reports full.
- R2: A `tx_push_i` pulse queues the byte on `tx_data_i` as a write. When the write is served, the select goes low and exactly 8 rising clock edges follow. At those edges `sio_o` carries the byte, most significant bit first. `sio_oe_o` is 1 at every one of those edges.
- R3: A `rd_req_i` pulse queues a read. When the read is served, `sio_oe_o` stays 0 for the whole frame. `sio_i` is sampled at each of the 8 rising edges, most significant bit first, and the assembled byte is pushed into the receive queue. `rx_data_o` shows the oldest entry, and `rx_pop_i` removes it. `sio_oe_o` is never 1 while the select is high.
- R4: Each high phase and each low phase of the serial clock lasts `div_i + 1` system clocks. The first rising edge comes `div_i + 1` clocks after the select falls. The select rises `div_i + 1` clocks after the last falling edge. The clock is low whenever the select is high.
- R5: The divider value is captured when a transfer starts. Changing `div_i` during a transfer does not alter that transfer's timing. The next transfer uses the new value.
- R6: The command queue holds 4 requests and raises `tx_full_o` when it holds 4. A push or read request made while it is full is dropped. Writes and reads are served in the order they were requested.
- R7: The receive queue holds 4 bytes. A read that reaches the head of the command queue while the receive queue is full is not started, and the select stays high. It starts once `rx_pop_i` frees an entry.
- R8: If `tx_push_i` and `rd_req_i` are both asserted in the same cycle, only the write is queued and the read request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | DIV_W (8) | Half-period length minus one, in system clocks |
| tx_data_i | input | DATA_W (8) | Byte to write |
| tx_push_i | input | 1 | Queue a write of `tx_data_i` |
| rd_req_i | input | 1 | Queue a read |
| tx_full_o | output | 1 | Command queue holds 4 requests |
| tx_empty_o | output | 1 | Command queue holds no request |
| rx_pop_i | input | 1 | Remove the oldest received byte |
| rx_data_o | output | DATA_W (8) | Oldest received byte |
| rx_full_o | output | 1 | Receive queue holds 4 bytes |
| rx_empty_o | output | 1 | Receive queue holds no byte |
| sck_o | output | 1 | Serial clock, idle low |
| ss_n_o | output | 1 | Active-low slave select |
| sio_o | output | 1 | Outgoing bit for the shared data pad |
| sio_oe_o | output | 1 | Output enable of the shared data pad |
| sio_i | input | 1 | Incoming bit from the shared data pad |

## Verification
The assertions check several rules on every cycle. The clock must stay low and the pad must stay undriven while the select is high. A rising clock edge may only occur with the select already low. Written data may not change during a clock high phase. No byte may enter a full receive queue, and no queue count may exceed its depth. Other behaviour can only be shown by the bench's scenarios. These are exact byte values for every write and read pattern, the measured half-period lengths across divider settings and their capture at transfer start, the ordering of mixed reads and writes, the dropping of requests into a full queue, the stall on a full receive queue, and the priority of a write over a simultaneous read.

// File: rtl/spi3w_pkg.sv
// Package: shared types for the three-wire SPI master.
// Assumes: nothing beyond IEEE 1800-2017.
package spi3w_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } spi3w_state_t;
endpackage

// File: rtl/spi3w_fifo.sv
// Module: spi3w_fifo
// Synchronous queue with show-ahead read data and full/empty flags.
// Assumes: a push while full and a pop while empty are ignored.
module spi3w_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Store an accepted entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= wdata;
        end
    end

    // Advance pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (!do_push && do_pop) begin
                count <= count - 1'b1;
            end
        end
    end

    // R6 R7: occupancy never exceeds the depth.
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R6: an ignored push leaves the count unchanged.
    p_full_push_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/spi3w_halftimer.sv
// Module: spi3w_halftimer
// Counts out half periods of the serial clock. It captures the divider
// when a transfer is loaded, so a later change to the divider input
// cannot affect a running transfer.
// Assumes: load and run are never both high.
module spi3w_halftimer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == '0);

    // Latch the divider at load and count down each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            div_q <= load_val;
            cnt   <= load_val;
        end else if (tick) begin
            cnt <= div_q;
        end else if (run) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R5: the latched divider stays fixed while a transfer runs.
    p_div_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(div_q));
endmodule

// File: rtl/spi3w_engine.sv
// Module: spi3w_engine
// Frame sequencer. A frame has 2*DATA_W+1 half periods. Phase 0 is the
// select-to-first-edge gap. Odd phases are clock high, even phases after 0
// are clock low, and the final low phase is the trailing gap before the
// select rises. Writes drive the pad and shift on falling edges. Reads
// release the pad and sample on rising edges.
// Assumes: the command source holds cmd_valid until cmd_take.
module spi3w_engine
    import spi3w_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_rd,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              rx_full,
    input  logic [DIV_W-1:0]  div,
    output logic              cmd_take,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic              sio_o,
    output logic              sio_oe_o,
    input  logic              sio_i
);
    localparam int LAST_PH = 2 * DATA_W;
    localparam int PH_W    = $clog2(LAST_PH + 1);

    spi3w_state_t      st;
    logic [PH_W-1:0]   ph;
    logic              rd_q;
    logic [DATA_W-1:0] sh;
    logic              tick;
    logic              last_ph;

    assign last_ph  = (ph == PH_W'(LAST_PH));
    assign cmd_take = (st == ST_IDLE) && cmd_valid && (!cmd_rd || !rx_full);
    assign rx_push  = (st == ST_RUN) && tick && last_ph && rd_q;
    assign rx_byte  = sh;
    assign sio_o    = sio_oe_o && sh[DATA_W-1];

    spi3w_halftimer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_take),
        .load_val (div),
        .run      (st == ST_RUN),
        .tick     (tick)
    );

    // Sequence a frame: select, clock phases, shifting, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ph       <= '0;
            rd_q     <= 1'b0;
            sh       <= '0;
            sck_o    <= 1'b0;
            ss_n_o   <= 1'b1;
            sio_oe_o <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cmd_take) begin
                        st       <= ST_RUN;
                        ph       <= '0;
                        rd_q     <= cmd_rd;
                        sh       <= cmd_rd ? '0 : cmd_data;
                        sck_o    <= 1'b0;
                        ss_n_o   <= 1'b0;
                        sio_oe_o <= !cmd_rd;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (last_ph) begin
                            st       <= ST_IDLE;
                            ss_n_o   <= 1'b1;
                            sio_oe_o <= 1'b0;
                            sck_o    <= 1'b0;
                        end else begin
                            ph    <= ph + 1'b1;
                            sck_o <= !ph[0];
                            if (!ph[0] && rd_q) begin
                                sh <= {sh[DATA_W-2:0], sio_i};
                            end
                            if (ph[0] && !rd_q) begin
                                sh <= {sh[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4: the clock idles low whenever the select is high.
    p_sck_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sck_o);

    // R4: a rising clock edge only follows an already asserted select.
    p_select_before_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> ($past(!ss_n_o) && !ss_n_o));

    // R3: the pad is never driven while deselected.
    p_no_drive_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sio_oe_o);

    // R2: outgoing data holds still through each clock high phase.
    p_data_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(sio_o));

    // R3: the output enable does not toggle inside a frame.
    p_oe_frame_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n_o && $past(!ss_n_o)) |-> $stable(sio_oe_o));
endmodule

// File: rtl/spi3w_master.sv
// Module: spi3w_master (top)
// Three-wire half-duplex SPI master. A shared command queue orders writes
// and reads. A receive queue collects read bytes. The frame engine drives
// the serial clock, the select and the pad enable.
// Assumes: the pad is modelled as out/enable/in. A write wins over a read
// requested in the same cycle.
module spi3w_master #(
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_push_i,
    input  logic              rd_req_i,
    output logic              tx_full_o,
    output logic              tx_empty_o,
    input  logic              rx_pop_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              rx_empty_o,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic              sio_o,
    output logic              sio_oe_o,
    input  logic              sio_i
);
    localparam int CMD_W = DATA_W + 1;

    logic [CMD_W-1:0]  cmd_wdata;
    logic [CMD_W-1:0]  cmd_head;
    logic              cmd_push;
    logic              cmd_take;
    logic              rx_push;
    logic [DATA_W-1:0] rx_byte;

    assign cmd_push  = tx_push_i || rd_req_i;
    assign cmd_wdata = {!tx_push_i, tx_push_i ? tx_data_i : {DATA_W{1'b0}}};

    spi3w_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_cmd_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_push),
        .wdata (cmd_wdata),
        .pop   (cmd_take),
        .rdata (cmd_head),
        .full  (tx_full_o),
        .empty (tx_empty_o)
    );

    spi3w_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (!tx_empty_o),
        .cmd_rd    (cmd_head[DATA_W]),
        .cmd_data  (cmd_head[DATA_W-1:0]),
        .rx_full   (rx_full_o),
        .div       (div_i),
        .cmd_take  (cmd_take),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .sck_o     (sck_o),
        .ss_n_o    (ss_n_o),
        .sio_o     (sio_o),
        .sio_oe_o  (sio_oe_o),
        .sio_i     (sio_i)
    );

    spi3w_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_pop_i),
        .rdata (rx_data_o),
        .full  (rx_full_o),
        .empty (rx_empty_o)
    );

    // R7: a received byte never arrives at a full receive queue.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full_o);

    // R7: a read is never taken while the receive queue is full.
    p_read_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && cmd_head[DATA_W]) |-> !rx_full_o);
endmodule

// File: tb/spi3w_master_test.sv
// Bench for spi3w_master: byte sweeps, divider sweeps and queue corner cases.
module spi3w_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic [7:0] tx_data_i = 8'd0;
    logic       tx_push_i = 1'b0;
    logic       rd_req_i = 1'b0;
    logic       rx_pop_i = 1'b0;
    logic       sio_i = 1'b0;
    logic       tx_full_o, tx_empty_o, rx_full_o, rx_empty_o;
    logic [7:0] rx_data_o;
    logic       sck_o, ss_n_o, sio_o, sio_oe_o;

    spi3w_master uut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .tx_data_i(tx_data_i),
        .tx_push_i(tx_push_i), .rd_req_i(rd_req_i), .tx_full_o(tx_full_o),
        .tx_empty_o(tx_empty_o), .rx_pop_i(rx_pop_i), .rx_data_o(rx_data_o),
        .rx_full_o(rx_full_o), .rx_empty_o(rx_empty_o), .sck_o(sck_o),
        .ss_n_o(ss_n_o), .sio_o(sio_o), .sio_oe_o(sio_oe_o), .sio_i(sio_i)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int nframes = 0;
    int nreq = 0;
    logic [7:0] cap_byte [1024];
    int         cap_oe   [1024];
    logic [7:0] slv      [1024];
    logic [7:0] exp_byte [1024];
    int         exp_oe   [1024];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor and slave model, sampled on the falling system clock edge.
    logic       sck_p = 1'b0;
    logic       ss_p = 1'b1;
    int         since = 0;
    int         frame_h = 1;
    int         rises = 0;
    int         sbit = 7;
    logic [7:0] wbyte = 8'd0;
    bit         oe1 = 1'b1;
    bit         oe0 = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            since++;
            if (ss_p && !ss_n_o) begin
                frame_h = int'(div_i) + 1;
                since = 0; rises = 0; wbyte = 8'd0; oe1 = 1'b1; oe0 = 1'b1;
                sbit = 7;
                sio_i = slv[nframes][7];
            end else if (!sck_p && sck_o) begin
                chk(since == frame_h, "R4 R5 half period (rise)", since, frame_h);
                since = 0;
                rises++;
                wbyte = {wbyte[6:0], sio_o};
                if (sio_oe_o) oe0 = 1'b0; else oe1 = 1'b0;
            end else if (sck_p && !sck_o) begin
                chk(since == frame_h, "R4 R5 half period (fall)", since, frame_h);
                since = 0;
                sbit--;
                if (sbit >= 0) sio_i = slv[nframes][sbit];
            end else if (!ss_p && ss_n_o) begin
                chk(since == frame_h, "R4 trailing select gap", since, frame_h);
                chk(rises == 8, "R2 R3 rising edges per frame", rises, 8);
                cap_byte[nframes] = wbyte;
                cap_oe[nframes] = oe1 ? 1 : (oe0 ? 0 : 2);
                nframes++;
            end
            sck_p = sck_o;
            ss_p = ss_n_o;
        end
    end

    task automatic do_write(input logic [7:0] b);
        @(negedge clk);
        tx_data_i = b; tx_push_i = 1'b1;
        @(negedge clk);
        tx_push_i = 1'b0;
        slv[nreq] = 8'd0; exp_byte[nreq] = b; exp_oe[nreq] = 1; nreq++;
    endtask

    task automatic do_read(input logic [7:0] s);
        slv[nreq] = s; exp_byte[nreq] = s; exp_oe[nreq] = 0; nreq++;
        @(negedge clk);
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        for (int t = 0; t < 20000 && nframes < n; t++) @(negedge clk);
        chk(nframes >= n, "frame completion", nframes, n);
    endtask

    task automatic check_frame(input int i, input string tag);
        chk(cap_oe[i] == exp_oe[i], {tag, " output enable over frame"}, cap_oe[i], exp_oe[i]);
        if (exp_oe[i] == 1)
            chk(cap_byte[i] == exp_byte[i], {tag, " written byte"}, int'(cap_byte[i]), int'(exp_byte[i]));
    endtask

    task automatic pop_rx(input logic [7:0] e, input string tag);
        @(negedge clk);
        chk(!rx_empty_o, {tag, " receive queue not empty"}, int'(rx_empty_o), 0);
        chk(rx_data_o == e, {tag, " received byte"}, int'(rx_data_o), int'(e));
        rx_pop_i = 1'b1;
        @(negedge clk);
        rx_pop_i = 1'b0;
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ss_n_o == 1'b1, "R1 select high", int'(ss_n_o), 1);
        chk(sck_o == 1'b0, "R1 clock low", int'(sck_o), 0);
        chk(sio_oe_o == 1'b0, "R1 pad released", int'(sio_oe_o), 0);
        chk(tx_empty_o && rx_empty_o, "R1 queues empty", int'({tx_empty_o, rx_empty_o}), 3);
        chk(!tx_full_o && !rx_full_o, "R1 queues not full", int'({tx_full_o, rx_full_o}), 0);

        // R2 every byte value written at the fastest divider
        div_i = 8'd0;
        for (int b = 0; b < 256; b++) begin
            do_write(8'(b));
            wait_frames(nreq);
            check_frame(nreq - 1, "R2");
        end

        // R3 every byte value read at the fastest divider
        for (int s = 0; s < 256; s++) begin
            do_read(8'(s));
            wait_frames(nreq);
            check_frame(nreq - 1, "R3");
            pop_rx(8'(s), "R3");
        end

        // R4 divider sweep with writes and reads
        for (int d = 1; d < 6; d++) begin
            div_i = 8'(d);
            do_write(8'hA5 ^ 8'(d));
            wait_frames(nreq);
            check_frame(nreq - 1, "R4");
            do_read(8'h3C + 8'(d));
            wait_frames(nreq);
            check_frame(nreq - 1, "R4");
            pop_rx(8'h3C + 8'(d), "R4");
        end

        // R5 divider change mid-transfer applies only to the next one
        div_i = 8'd3;
        do_write(8'h96);
        for (int t = 0; t < 200 && ss_n_o; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        div_i = 8'd9;
        wait_frames(nreq);
        check_frame(nreq - 1, "R5");
        do_write(8'h69);
        wait_frames(nreq);
        check_frame(nreq - 1, "R5");

        // R6 queue full flag and drop of a push while full
        div_i = 8'd7;
        base = nreq;
        do_write(8'h11);
        for (int t = 0; t < 200 && ss_n_o; t++) @(negedge clk);
        do_write(8'h22); do_write(8'h33); do_write(8'h44); do_write(8'h55);
        chk(tx_full_o, "R6 command queue full", int'(tx_full_o), 1);
        @(negedge clk);
        tx_data_i = 8'h66; tx_push_i = 1'b1;
        @(negedge clk);
        tx_push_i = 1'b0;
        wait_frames(nreq);
        repeat (300) @(negedge clk);
        chk(nframes == base + 5, "R6 dropped push not sent", nframes - base, 5);
        for (int i = base; i < base + 5; i++) check_frame(i, "R6");
        chk(tx_empty_o, "R6 command queue drained", int'(tx_empty_o), 1);

        // R6 mixed order of writes and reads
        div_i = 8'd1;
        base = nreq;
        do_write(8'hC3); do_read(8'h5A); do_write(8'h0F); do_read(8'hE1);
        wait_frames(nreq);
        for (int i = base; i < base + 4; i++) check_frame(i, "R6 order");
        pop_rx(8'h5A, "R6 order");
        pop_rx(8'hE1, "R6 order");

        // R7 read stalls while the receive queue is full
        div_i = 8'd0;
        base = nreq;
        for (int k = 1; k <= 5; k++) do_read(8'(k * 17));
        wait_frames(base + 4);
        repeat (100) @(negedge clk);
        chk(nframes == base + 4, "R7 fifth read stalled", nframes - base, 4);
        chk(rx_full_o, "R7 receive queue full", int'(rx_full_o), 1);
        chk(ss_n_o, "R7 select stays high during stall", int'(ss_n_o), 1);
        pop_rx(8'd17, "R7");
        wait_frames(base + 5);
        for (int k = 2; k <= 5; k++) pop_rx(8'(k * 17), "R7");
        chk(rx_empty_o, "R7 receive queue empty", int'(rx_empty_o), 1);

        // R8 simultaneous write and read: only the write is queued
        base = nreq;
        @(negedge clk);
        tx_data_i = 8'h77; tx_push_i = 1'b1; rd_req_i = 1'b1;
        @(negedge clk);
        tx_push_i = 1'b0; rd_req_i = 1'b0;
        slv[nreq] = 8'd0; exp_byte[nreq] = 8'h77; exp_oe[nreq] = 1; nreq++;
        wait_frames(nreq);
        repeat (100) @(negedge clk);
        chk(nframes == base + 1, "R8 only one frame", nframes - base, 1);
        check_frame(base, "R8");
        chk(rx_empty_o, "R8 no byte received", int'(rx_empty_o), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule